// File: doc/BRIEF.md
# Hot-Plug Slot Event Latch and Interrupt Locator

The block watches a set of hot-plug slots and remembers what happened to them. Each slot supplies five live inputs: a two-bit card-presence code, a retention-latch sensor, an attention button, and two active-low power-fault indications, one for the isolated supply and one for the connected supply. Every input passes through a two-flop synchroniser. An edge detector then turns each change of interest into a sticky event bit in that slot's 32-bit register. Software clears an event by writing a one to it. The same register holds per-event interrupt masks and two error-signalling mask bits. It also shows the present synchronised input levels.

A controller register holds four global mask bits and two sticky detected flags. One flag is set by a command-complete pulse and the other by an arbiter-timeout pulse. A read-only locator word summarises every interrupt source. Bit 0 is the unmasked command-complete event and bit i+1 is slot i. A single interrupt line is raised whenever the locator is non-zero and the global interrupt mask is clear. Software uses the locator to find the slot that needs service, reads that slot's register, handles the events and writes them back to clear them.

Register access is a plain single-cycle port. A write takes effect at the clock edge while `wr_en` is high. Reads are combinational from `rd_addr`. Word address 0 is the controller register, 1 is the locator, and 2+i is slot i. There is no back-pressure: every access completes in one cycle.

Top module: `slot_evt_ctrl`

## Requirements
- R1: After reset, every slot register reads its masks set (bits 30:24 all ones) with no events, the controller register reads 0x0000000F, the locator reads 0 and `irq` is low.
- R2: A slot event bit is set when a synchronised input edge is detected. Bit 16 is set by any change of the presence code. Bit 17 is set when the isolated power-fault input falls to 0 (fault). Bit 18 is set by a rising edge of the button, and not by its release. Bit 19 is set by either edge of the latch sensor. Bit 20 is set when the connected power-fault input falls to 0.
- R3: A slot register shows the synchronised live inputs: presence code at bits 11:10 (3 = empty), latch sensor at bit 8 (1 = open), button at bit 7, and the isolated power-fault level at bit 6 (0 = fault).
- R4: Writing a one to a slot event bit (20:16) clears it, and writing zero leaves it unchanged. Bits 30:24 are read/write masks: 28:24 mask the interrupts of events 20:16 in the same order, 29 masks the latch error signal and 30 masks the connected-fault error signal.
- R5: When a new event and a write-one-to-clear of the same bit arrive in the same cycle, the event bit stays set.
- R6: Slot register bits 31, 23:21 and 15 always read zero. Controller register bits 31:18 and 15:4 always read zero.
- R7: Locator bit i+1 is one exactly when slot i holds an event whose interrupt mask bit is 0. Bit 0 is one when the command-complete flag is set and the command mask (controller bit 2) is 0. Bits above the slot count read zero.
- R8: `irq` is high when the locator is non-zero and the global interrupt mask (controller bit 0) is 0. Setting that mask drops `irq` without clearing any event, so clearing the mask again raises `irq`.
- R9: A `cmd_done` pulse sets controller bit 16 and an `arb_tmo` pulse sets bit 17, one cycle later. Both flags clear by writing one. Controller bits 3:0 are read/write masks.
- R10: Writes to the locator address have no effect, and reads of word addresses beyond the last slot return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word address of the combinational read |
| rd_data | output | 32 | Read data |
| cmd_done | input | 1 | One-cycle command-complete pulse |
| arb_tmo | input | 1 | One-cycle arbiter-timeout pulse |
| prsnt | input | 2*N_SLOTS | Presence code per slot, 3 = empty |
| latch_open | input | N_SLOTS | Latch sensor per slot, 1 = open |
| button | input | N_SLOTS | Attention button per slot, 1 = pressed |
| iso_pf_n | input | N_SLOTS | Isolated power fault per slot, 0 = fault |
| con_pf_n | input | N_SLOTS | Connected power fault per slot, 0 = fault |
| irq | output | 1 | Interrupt request |

## Verification
The edge logic is tested with single-input toggles in both directions. This separates level-sensitive from edge-sensitive capture and catches a wrong polarity on the button and on both fault inputs. A multi-input change on one slot checks that each event lands in its own bit and that the live status fields track the inputs. Mask patterns that hide one event while exposing another separate the locator's per-event gating from simple event OR-ing. Toggling the global mask with events pending shows that the mask gates the interrupt line and does not clear state. A clear issued in exactly the cycle a new edge is latched shows which of the two wins.

// File: rtl/hpe_pkg.sv
package hpe_pkg;
  localparam int EV_W   = 5;
  localparam int EV_LSB = 16;
  localparam int IM_LSB = 24;
  localparam int SM_LSB = 29;
  localparam int SM_W   = 2;
  localparam int PRS_LSB = 10;
  localparam int LAT_BIT = 8;
  localparam int BTN_BIT = 7;
  localparam int IPF_BIT = 6;
  localparam int CTL_MASK_W = 4;
  localparam int CTL_DET_LSB = 16;
  localparam logic [31:0] SLOT_RSVD = 32'h80E0_8000;

  // event index order inside the 5-bit event vector
  localparam int E_PRS = 0;
  localparam int E_IPF = 1;
  localparam int E_BTN = 2;
  localparam int E_LAT = 3;
  localparam int E_CPF = 4;

  typedef struct packed {
    logic [1:0] prs;
    logic       lat;
    logic       btn;
    logic       ipf_n;
    logic       cpf_n;
  } slot_in_t;

  localparam int SLOT_IN_W = $bits(slot_in_t);
  localparam slot_in_t SLOT_IDLE = '{prs: 2'b11, lat: 1'b0, btn: 1'b0, ipf_n: 1'b1, cpf_n: 1'b1};
endpackage

// File: rtl/hpe_sync.sv
module hpe_sync #(
  parameter int          W       = 7,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[s] <= RST_VAL;
      else if (s == 0) st[s] <= d;
      else st[s] <= st[(s == 0) ? 0 : s - 1];
    end
  end

  assign q = st[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_d <= RST_VAL;
    else q_d <= q;
  end
endmodule

// File: rtl/hpe_slot_reg.sv
module hpe_slot_reg
  import hpe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  slot_in_t          cur,
  input  slot_in_t          prev,
  input  logic              wr,
  input  logic [EV_W-1:0]   wr_ev,
  input  logic [EV_W-1:0]   wr_im,
  input  logic [SM_W-1:0]   wr_sm,
  output logic [31:0]       rdata,
  output logic [EV_W-1:0]   ev,
  output logic              pend
);
  logic [EV_W-1:0] set_ev, clr_ev, imask;
  logic [SM_W-1:0] smask;

  always_comb begin
    set_ev        = '0;
    set_ev[E_PRS] = cur.prs != prev.prs;
    set_ev[E_IPF] = prev.ipf_n & ~cur.ipf_n;
    set_ev[E_BTN] = cur.btn & ~prev.btn;
    set_ev[E_LAT] = cur.lat ^ prev.lat;
    set_ev[E_CPF] = prev.cpf_n & ~cur.cpf_n;
    clr_ev        = wr ? wr_ev : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev    <= '0;
      imask <= '1;
      smask <= '1;
    end else begin
      ev <= (ev & ~clr_ev) | set_ev;
      if (wr) begin
        imask <= wr_im;
        smask <= wr_sm;
      end
    end
  end

  assign pend = |(ev & ~imask);

  always_comb begin
    rdata                       = '0;
    rdata[EV_LSB +: EV_W]       = ev;
    rdata[IM_LSB +: EV_W]       = imask;
    rdata[SM_LSB +: SM_W]       = smask;
    rdata[PRS_LSB +: 2]         = cur.prs;
    rdata[LAT_BIT]              = cur.lat;
    rdata[BTN_BIT]              = cur.btn;
    rdata[IPF_BIT]              = cur.ipf_n;
  end
endmodule

// File: rtl/hpe_ctl_reg.sv
module hpe_ctl_reg
  import hpe_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_done,
  input  logic                  arb_tmo,
  input  logic                  wr,
  input  logic [CTL_MASK_W-1:0] wr_mask,
  input  logic [1:0]            wr_det,
  output logic [31:0]           rdata,
  output logic [1:0]            det,
  output logic                  glb_mask,
  output logic                  cmd_pend
);
  logic [CTL_MASK_W-1:0] mask;
  logic [1:0] clr;

  assign clr = wr ? wr_det : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '1;
      det  <= '0;
    end else begin
      det <= (det & ~clr) | {arb_tmo, cmd_done};
      if (wr) mask <= wr_mask;
    end
  end

  assign glb_mask = mask[0];
  assign cmd_pend = det[0] & ~mask[2];

  always_comb begin
    rdata                       = '0;
    rdata[CTL_MASK_W-1:0]       = mask;
    rdata[CTL_DET_LSB +: 2]     = det;
  end
endmodule

// File: rtl/slot_evt_ctrl.sv
module slot_evt_ctrl
  import hpe_pkg::*;
#(
  parameter  int N_SLOTS = 4,
  localparam int ADDR_W  = $clog2(N_SLOTS + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [31:0]          rd_data,
  input  logic                 cmd_done,
  input  logic                 arb_tmo,
  input  logic [2*N_SLOTS-1:0] prsnt,
  input  logic [N_SLOTS-1:0]   latch_open,
  input  logic [N_SLOTS-1:0]   button,
  input  logic [N_SLOTS-1:0]   iso_pf_n,
  input  logic [N_SLOTS-1:0]   con_pf_n,
  output logic                 irq
);
  localparam int LOC_W   = 32;
  localparam int CTL_A   = 0;
  localparam int LOC_A   = 1;
  localparam int SLOT0_A = 2;

  logic [31:0]            slot_rd [N_SLOTS];
  logic [N_SLOTS*EV_W-1:0] ev_flat;
  logic [N_SLOTS-1:0]     slot_pend;
  logic [31:0]            ctl_rd;
  logic [1:0]             ctl_det;
  logic                   glb_mask, cmd_pend;
  logic [LOC_W-1:0]       loc_word;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    slot_in_t raw, cur, prev;
    logic     sel;

    assign raw.prs   = prsnt[2*i +: 2];
    assign raw.lat   = latch_open[i];
    assign raw.btn   = button[i];
    assign raw.ipf_n = iso_pf_n[i];
    assign raw.cpf_n = con_pf_n[i];
    assign sel = wr_en && (int'(wr_addr) == SLOT0_A + i);

    hpe_sync #(.W(SLOT_IN_W), .STAGES(2), .RST_VAL(SLOT_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(cur), .q_d(prev)
    );

    hpe_slot_reg u_reg (
      .clk(clk), .rst_n(rst_n), .cur(cur), .prev(prev), .wr(sel),
      .wr_ev(wr_data[EV_LSB +: EV_W]),
      .wr_im(wr_data[IM_LSB +: EV_W]),
      .wr_sm(wr_data[SM_LSB +: SM_W]),
      .rdata(slot_rd[i]), .ev(ev_flat[i*EV_W +: EV_W]), .pend(slot_pend[i])
    );
  end

  hpe_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .arb_tmo(arb_tmo),
    .wr(wr_en && (int'(wr_addr) == CTL_A)),
    .wr_mask(wr_data[CTL_MASK_W-1:0]),
    .wr_det(wr_data[CTL_DET_LSB +: 2]),
    .rdata(ctl_rd), .det(ctl_det), .glb_mask(glb_mask), .cmd_pend(cmd_pend)
  );

  always_comb begin
    loc_word                = '0;
    loc_word[0]             = cmd_pend;
    loc_word[N_SLOTS:1]     = slot_pend;
  end

  assign irq = (|loc_word) & ~glb_mask;

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) == CTL_A) rd_data = ctl_rd;
    else if (int'(rd_addr) == LOC_A) rd_data = loc_word;
    else begin
      for (int i = 0; i < N_SLOTS; i++)
        if (int'(rd_addr) == SLOT0_A + i) rd_data = slot_rd[i];
    end
  end
endmodule

// File: rtl/hpe_chk.sv
module hpe_chk
  import hpe_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int ADDR_W  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       wr_addr,
  input logic [ADDR_W-1:0]       rd_addr,
  input logic [31:0]             rd_data,
  input logic                    cmd_done,
  input logic                    arb_tmo,
  input logic [N_SLOTS*EV_W-1:0] ev_flat,
  input logic [1:0]              ctl_det,
  input logic                    glb_mask,
  input logic [31:0]             loc_word,
  input logic                    irq
);
  // R8: the global mask silences the interrupt line
  p_gmask_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    glb_mask |-> !irq);

  // R8: an interrupt always has a locator source
  p_irq_has_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (loc_word != 32'd0));

  // R9: command and arbiter pulses are captured on the next edge
  p_cmd_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> ctl_det[0]);
  p_arb_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arb_tmo |=> ctl_det[1]);

  // R7: locator bits past the slot range stay zero
  p_loc_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_word >> (N_SLOTS + 1)) == 32'd0);

  // R6: reserved slot bits read zero
  p_slot_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(rd_addr) >= 2) && (int'(rd_addr) < N_SLOTS + 2)) |-> ((rd_data & SLOT_RSVD) == 32'd0));

  // R4: event bits only fall after a write to that slot
  for (genvar i = 0; i < N_SLOTS; i++) begin : g_st
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en && (int'(wr_addr) == i + 2)) |->
        ((ev_flat[i*EV_W +: EV_W] & $past(ev_flat[i*EV_W +: EV_W])) == $past(ev_flat[i*EV_W +: EV_W])));
  end
endmodule

bind slot_evt_ctrl hpe_chk #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
  .rd_data(rd_data), .cmd_done(cmd_done), .arb_tmo(arb_tmo), .ev_flat(ev_flat),
  .ctl_det(ctl_det), .glb_mask(glb_mask), .loc_word(loc_word), .irq(irq)
);

// File: tb/sim_slot_evt_ctrl.sv
module sim_slot_evt_ctrl;
  localparam int N = 4;
  localparam int AW = $clog2(N + 2);
  localparam time CLK_PER = 10ns;
  localparam logic [31:0] MASKS = 32'h7F00_0000;
  localparam logic [31:0] IDLE_ST = 32'h0000_0C40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, cmd_done = 1'b0, arb_tmo = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [2*N-1:0] prsnt = '1;
  logic [N-1:0] latch_open = '0, button = '0, iso_pf_n = '1, con_pf_n = '1;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  slot_evt_ctrl #(.N_SLOTS(N)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(int a, output logic [31:0] v);
    rd_addr = AW'(a);
    #1;
    v = rd_data;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); chk("R1 ctl", v, 32'h0000_000F);
    rd(1, v); chk("R1 loc", v, 32'h0);
    rd(2, v); chk("R1 slot0", v, MASKS | IDLE_ST);
    rd(5, v); chk("R1 slot3", v, MASKS | IDLE_ST);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    @(negedge clk);
    prsnt[3:2] = 2'b01; latch_open[1] = 1'b1; button[1] = 1'b1; iso_pf_n[1] = 1'b0;
    settle();
    rd(3, v);
    chk("R3 status", v & 32'hFFFF, 32'h0000_0580);
    chk("R2 multi-event", v & 32'h001F_0000, 32'h000F_0000);
    @(negedge clk);
    prsnt[3:2] = 2'b11; latch_open[1] = 1'b0; button[1] = 1'b0; iso_pf_n[1] = 1'b1;
    settle();
    wr(3, MASKS | 32'h001F_0000);
    rd(3, v); chk("R4 clear all", v, MASKS | IDLE_ST);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    @(negedge clk); button[2] = 1'b1; settle();
    rd(4, v); chk("R2 button press", v & 32'h001F_0000, 32'h0004_0000);
    wr(4, MASKS | 32'h001F_0000);
    @(negedge clk); button[2] = 1'b0; settle();
    rd(4, v); chk("R2 button release ignored", v & 32'h001F_0000, 32'h0);
    @(negedge clk); con_pf_n[2] = 1'b0; settle();
    rd(4, v); chk("R2 con fault", v & 32'h001F_0000, 32'h0010_0000);
    wr(4, MASKS | 32'h001F_0000);
    @(negedge clk); con_pf_n[2] = 1'b1; settle();
    rd(4, v); chk("R2 con fault recovery ignored", v & 32'h001F_0000, 32'h0);
    @(negedge clk); iso_pf_n[2] = 1'b0; settle();
    @(negedge clk); iso_pf_n[2] = 1'b1; settle();
    rd(4, v); chk("R2 iso fault once", v & 32'h001F_0000, 32'h0002_0000);
    wr(4, MASKS | 32'h001F_0000);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    @(negedge clk); latch_open[2] = 1'b1; settle();
    @(negedge clk); latch_open[2] = 1'b0; settle();
    wr(4, MASKS);
    rd(4, v); chk("R4 write zero keeps", v & 32'h001F_0000, 32'h0008_0000);
    wr(4, MASKS | 32'h0008_0000);
    rd(4, v); chk("R4 write one clears", v & 32'h001F_0000, 32'h0);
    wr(4, 32'h0);
    rd(4, v); chk("R4 masks writable", v, IDLE_ST);
    wr(4, 32'hFFFF_FFFF);
    rd(4, v); chk("R6 slot reserved", v, MASKS | IDLE_ST);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    @(negedge clk); button[3] = 1'b1; settle();
    @(negedge clk); button[3] = 1'b0; settle();
    @(negedge clk); button[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(5, MASKS | 32'h0004_0000);
    rd(5, v); chk("R5 event beats clear", v & 32'h001F_0000, 32'h0004_0000);
    wr(5, MASKS | 32'h0004_0000);
    rd(5, v); chk("R5 later clear", v & 32'h001F_0000, 32'h0);
    @(negedge clk); button[3] = 1'b0; settle();
  endtask

  task automatic t_locator();
    logic [31:0] v;
    wr(3, 32'h7700_0000);
    @(negedge clk); button[1] = 1'b1; settle();
    rd(1, v); chk("R7 masked event hidden", v, 32'h0);
    @(negedge clk); latch_open[1] = 1'b1; settle();
    rd(1, v); chk("R7 unmasked slot1", v, 32'h0000_0004);
    chk("R8 global mask holds irq", 32'(irq), 32'h0);
    wr(0, 32'h0000_000E);
    #1; chk("R8 irq on", 32'(irq), 32'h1);
    wr(0, 32'h0000_000F);
    rd(1, v); chk("R8 mask keeps events", v, 32'h0000_0004);
    chk("R8 irq off", 32'(irq), 32'h0);
    wr(0, 32'h0000_000E);
    #1; chk("R8 irq back", 32'(irq), 32'h1);
    wr(3, 32'h771F_0000);
    rd(1, v); chk("R7 cleared", v, 32'h0);
    chk("R8 irq idle", 32'(irq), 32'h0);
    @(negedge clk); button[1] = 1'b0; latch_open[1] = 1'b0; settle();
    wr(3, MASKS | 32'h001F_0000);
  endtask

  task automatic t_ctl();
    logic [31:0] v;
    @(negedge clk); cmd_done = 1'b1; @(negedge clk); cmd_done = 1'b0;
    rd(0, v); chk("R9 cmd flag", v, 32'h0001_000E);
    rd(1, v); chk("R7 cmd masked", v, 32'h0);
    wr(0, 32'h0000_000A);
    rd(1, v); chk("R7 cmd locator", v, 32'h1);
    chk("R8 cmd irq", 32'(irq), 32'h1);
    @(negedge clk); arb_tmo = 1'b1; @(negedge clk); arb_tmo = 1'b0;
    rd(0, v); chk("R9 arb flag", v, 32'h0003_000A);
    wr(0, 32'h0003_000A);
    rd(0, v); chk("R9 flags clear", v, 32'h0000_000A);
    chk("R9 irq drop", 32'(irq), 32'h0);
    wr(0, 32'hFFFC_FFF5);
    rd(0, v); chk("R6 ctl reserved", v, 32'h0000_0005);
    wr(0, 32'h0000_000F);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R10 locator read-only", v, 32'h0);
    rd(0, v); chk("R10 ctl untouched", v, 32'h0000_000F);
    rd(6, v); chk("R10 unmapped read", v, 32'h0);
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_status();
    t_edges();
    t_w1c();
    t_collision();
    t_locator();
    t_ctl();
    t_unmapped();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule